// File: doc/BRIEF.md
# Relocatable Boot-ROM and RAM Chip-Select Decoder

This block decodes the 16-bit address bus of an 8-bit processor into chip selects for a bank of boot ROM devices and a pair of 32K x 8 static RAMs. It has no clock and no state. The outputs follow the address bus, the active-low memory-request strobe and two static control levels.

The ROM claims exactly one 4K window, and that window does not repeat anywhere else in memory. A relocate control places the window at the bottom of memory (0x0000) or at the top (0xF000). A disable control removes the ROM completely. Every address the ROM does not claim goes to RAM, so RAM covers 60K while the ROM is enabled and all 64K while it is disabled.

Both controls are active low. An unconnected control is read as high, which leaves the ROM enabled at 0x0000. The window match compares address bits 15..12 against the relocate level. A hit enables a 1-of-8 device decoder whose top select input is tied to 0, so address bits 11..10 pick one of four 1K ROM devices.

Top module: `rom_ram_decode`

## Requirements
- R1: While `mreq_n` is high, every ROM select and both RAM selects are high and `rom_sel` is low, whatever the address and controls.
- R2: With `hi_rom_n` high and `rom_on_n` high, an active request to 0x0000..0x0FFF asserts a ROM select.
- R3: With `hi_rom_n` low and `rom_on_n` high, an active request to 0xF000..0xFFFF asserts a ROM select.
- R4: No ROM select asserts outside the window chosen by `hi_rom_n`. The window is 0x0000..0x0FFF when `hi_rom_n` is high and 0xF000..0xFFFF when it is low.
- R5: Inside the window, `rom_cs_n[k]` is the only ROM select driven low, where k = address bits 11..10 (k runs 0..3). `rom_cs_n[7:4]` stay high at all times.
- R6: With `rom_on_n` low, no ROM select asserts at any address, and RAM answers every active request.
- R7: On an active request that the ROM does not claim, `ram_cs_n[b]` is low and the other RAM select is high, where b = address bit 15.
- R8: On every active request, exactly one of the ten select outputs is low.
- R9: `rom_sel` is high exactly when some ROM select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request strobe, active low |
| hi_rom_n | input | 1 | Low places the ROM window at 0xF000; high places it at 0x0000 |
| rom_on_n | input | 1 | Low disables the ROM entirely; high enables it |
| rom_cs_n | output | 8 | ROM device selects, active low; bits 7..4 unused and always high |
| ram_cs_n | output | 2 | RAM device selects, active low; bit 0 covers the lower 32K, bit 1 the upper 32K |
| rom_sel | output | 1 | High while a ROM device is selected |

## Verification
The hardest case is a ROM decode that leaks into the wrong places. This could be a mirror of the window, a window whose position does not follow the relocate level, or an overlap between ROM and RAM selects in the lower half of memory, which is what happens if bit 12 reaches the device decoder. A few directed addresses cannot rule these out. The bench therefore walks every one of the 65536 addresses under all four control combinations and compares each result with a model written from the requirements. This confirms that exactly one device answers at each address. A short vector table and idle-strobe checks before the sweep cover the window edges and the quiet state.

// File: rtl/rom_ram_decode.sv
module rom_ram_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 4,
  parameter int DEV_W  = 2,
  parameter int SEL_W  = 3,
  parameter int RAM_W  = 1
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    mreq_n,
  input  logic                    hi_rom_n,
  input  logic                    rom_on_n,
  output logic [(1<<SEL_W)-1:0]   rom_cs_n,
  output logic [(1<<RAM_W)-1:0]   ram_cs_n,
  output logic                    rom_sel
);
  localparam int DEC_N   = 1 << SEL_W;
  localparam int RAM_N   = 1 << RAM_W;
  localparam int DEV_LSB = ADDR_W - WIN_W - DEV_W;

  logic             win_hit;
  logic             dec_en;
  logic [SEL_W-1:0] dev_idx;
  logic [RAM_W-1:0] ram_idx;
  logic             unused_low;

  // each window bit must differ from the relocate level
  assign win_hit = &(addr[ADDR_W-1 -: WIN_W] ^ {WIN_W{hi_rom_n}});
  assign dec_en  = !mreq_n && rom_on_n && win_hit;
  assign dev_idx = {{(SEL_W-DEV_W){1'b0}}, addr[DEV_LSB +: DEV_W]};
  assign ram_idx = addr[ADDR_W-1 -: RAM_W];
  assign rom_sel = dec_en;
  assign unused_low = ^addr[DEV_LSB-1:0];

  for (genvar k = 0; k < DEC_N; k++) begin : g_rom
    assign rom_cs_n[k] = !(dec_en && (dev_idx == SEL_W'(k)));
  end

  for (genvar j = 0; j < RAM_N; j++) begin : g_ram
    assign ram_cs_n[j] = !(!mreq_n && !dec_en && (ram_idx == RAM_W'(j)));
  end
endmodule

// File: rtl/rom_ram_decode_chk.sv
module rom_ram_decode_chk (
  input logic [15:0] addr,
  input logic        mreq_n,
  input logic        hi_rom_n,
  input logic        rom_on_n,
  input logic [7:0]  rom_cs_n,
  input logic [1:0]  ram_cs_n,
  input logic        rom_sel
);
  always_comb begin
    AST_IDLE_QUIET: assert (!mreq_n || (&rom_cs_n && &ram_cs_n && !rom_sel)); // R1
    AST_SPARE_OFF: assert (&rom_cs_n[7:4]); // R5
    AST_NO_ROM_WHEN_OFF: assert (rom_on_n || &rom_cs_n); // R6
    AST_WINDOW_ONLY: assert (&rom_cs_n || addr[15:12] == (hi_rom_n ? 4'h0 : 4'hF)); // R4
    AST_ONE_DEVICE: assert (mreq_n || $countones({~rom_cs_n, ~ram_cs_n}) == 1); // R8
    AST_ROM_FLAG: assert (rom_sel == !(&rom_cs_n)); // R9
  end
endmodule

bind rom_ram_decode rom_ram_decode_chk u_chk (
  .addr(addr), .mreq_n(mreq_n), .hi_rom_n(hi_rom_n), .rom_on_n(rom_on_n),
  .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .rom_sel(rom_sel)
);

// File: tb/test_rom_ram_decode.sv
module test_rom_ram_decode;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] addr;
  logic        mreq_n, hi_rom_n, rom_on_n;
  logic [7:0]  rom_cs_n;
  logic [1:0]  ram_cs_n;
  logic        rom_sel;
  int          errors = 0, checks = 0, printed = 0;

  rom_ram_decode i_rom_ram_decode (
    .addr(addr), .mreq_n(mreq_n), .hi_rom_n(hi_rom_n), .rom_on_n(rom_on_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .rom_sel(rom_sel)
  );

  typedef struct packed {
    logic [15:0] a;
    logic        rq_n;
    logic        hi_n;
    logic        on_n;
    logic [10:0] exp;
  } vec_t;

  // exp = {rom_sel, ram_cs_n[1:0], rom_cs_n[7:0]}
  localparam vec_t TBL [12] = '{
    '{16'h0000, 1'b0, 1'b1, 1'b1, 11'b1_11_11111110},
    '{16'h0C00, 1'b0, 1'b1, 1'b1, 11'b1_11_11110111},
    '{16'h0FFF, 1'b0, 1'b1, 1'b1, 11'b1_11_11110111},
    '{16'h1000, 1'b0, 1'b1, 1'b1, 11'b0_10_11111111},
    '{16'h8000, 1'b0, 1'b1, 1'b1, 11'b0_01_11111111},
    '{16'hF000, 1'b0, 1'b1, 1'b1, 11'b0_01_11111111},
    '{16'hF400, 1'b0, 1'b0, 1'b1, 11'b1_11_11111101},
    '{16'h0000, 1'b0, 1'b0, 1'b1, 11'b0_10_11111111},
    '{16'h7FFF, 1'b0, 1'b0, 1'b1, 11'b0_10_11111111},
    '{16'h0800, 1'b0, 1'b1, 1'b0, 11'b0_10_11111111},
    '{16'hFFFF, 1'b0, 1'b0, 1'b0, 11'b0_01_11111111},
    '{16'h0400, 1'b1, 1'b1, 1'b1, 11'b0_11_11111111}
  };

  function automatic logic [10:0] model(logic [15:0] a, logic rq_n, logic hi_n, logic on_n);
    logic [7:0] r = 8'hFF;
    logic [1:0] m = 2'b11;
    logic       hit;
    if (rq_n) return {1'b0, m, r};
    hit = on_n && (a[15:12] == (hi_n ? 4'h0 : 4'hF));
    if (hit) r[a[11:10]] = 1'b0;
    else     m[a[15]] = 1'b0;
    return {hit, m, r};
  endfunction

  task automatic chk(string req, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (printed < 20) begin
        printed++;
        $display("FAIL %s addr=%h rq_n=%b hi_n=%b on_n=%b actual=%b expected=%b",
                 req, addr, mreq_n, hi_rom_n, rom_on_n, act, exp);
      end
    end
  endtask

  task automatic drive(logic [15:0] a, logic rq_n, logic hi_n, logic on_n);
    addr = a; mreq_n = rq_n; hi_rom_n = hi_n; rom_on_n = on_n;
    #1;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(16'h0000, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R1 idle after start", {rom_sel, ram_cs_n, rom_cs_n}, 11'b0_11_11111111);

    foreach (TBL[i]) begin
      drive(TBL[i].a, TBL[i].rq_n, TBL[i].hi_n, TBL[i].on_n);
      chk($sformatf("R2 R3 R4 R5 R6 R7 table row %0d", i),
          {rom_sel, ram_cs_n, rom_cs_n}, TBL[i].exp);
    end

    for (int c = 0; c < 4; c++) begin
      drive(16'hF3FF, 1'b1, c[1], c[0]);
      chk("R1 strobe idle", {rom_sel, ram_cs_n, rom_cs_n}, 11'b0_11_11111111);
    end

    // full sweep: R2 R3 R4 R5 R6 R7 R8 R9 under every control combination
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < 65536; a++) begin
        drive(16'(a), 1'b0, c[1], c[0]);
        chk("R8 sweep one device", 11'($countones({~rom_cs_n, ~ram_cs_n})), 11'd1);
        chk("R9 sweep flag", {10'd0, rom_sel}, {10'd0, !(&rom_cs_n)});
        chk("R4 R5 R6 R7 sweep", {rom_sel, ram_cs_n, rom_cs_n}, model(16'(a), 1'b0, c[1], c[0]));
      end
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule